// File: doc/BRIEF.md
# SRAM Bus-Cycle Mode Register Unlock Sequencer

This block sits beside an asynchronous-style SRAM interface and watches the ordinary bus cycles that the host already issues. The host has no separate register port. Instead, it performs a hidden command of four accesses, all to the highest address. The command is two reads followed by two writes. The second write carries a small configuration word. When the command is recognised, the block loads a three-bit mode register. That register holds a partial-refresh density code and a page-length flag. The register consumes no space in the memory map. The command accesses still reach the array as normal cycles; this block only observes them.

The strobes are sampled on a fast internal clock. A bus cycle lasts from the clock where chip select is first seen low to the clock where it is seen high again. The address, the write data and the strobe history gathered during that window decide how the cycle is classified. A finished command raises a one-clock done pulse. A command that goes wrong part way raises a one-clock fail pulse and leaves the register unchanged. A run of three or more top-address reads blocks any new command until some other address is accessed.

Top module: `sram_mode_unlock`

## Requirements
- R1: After reset, mode_valid, mode_density, mode_page8, seq_done and seq_fail are all 0.
- R2: A bus cycle ends at the first clock where cs_n is high after having been low. The cycle is a write if we_n was low on any clock of that window, and a read otherwise. The address used is the one on the last low clock. The data used is the one on the last clock where both cs_n and we_n were low.
- R3: The command is this exact sequence, with every access to the all-ones address: a read, a read, a write of all-zero data, then a write whose bit 2 is 1 and whose bits above bit 2 are all 0. On completion, mode_density takes bits 1:0 of the final data (00 = largest retained region, 11 = nothing retained), mode_page8 takes bit 2, and mode_valid becomes 1.
- R4: A command read only counts if oe_n goes from high to low during its cs_n-low window; an oe_n held low from before does not count. An uncounted top read ends any sequence in progress and blocks new commands, exactly as R8 describes.
- R5: If the first write carries non-zero data, the sequence aborts with a fail pulse and the register is unchanged.
- R6: If the final write has bit 2 clear or any bit above bit 2 set, the sequence aborts with a fail pulse and the register is unchanged.
- R7: An access to any address other than all-ones aborts a sequence in progress with a fail pulse. It also re-enables command entry. When no sequence is in progress, the same access causes no pulse.
- R8: A write where a read is expected, or a read where a write is expected, aborts with a fail pulse. A third consecutive top read also fails. After that read, top-address cycles neither start a sequence nor pulse, until a non-top access is seen.
- R9: seq_done and seq_fail are one-clock pulses, never high together, asserted on the clock after the clock that ends the deciding cycle.
- R10: The mode outputs change only with seq_done and hold otherwise; a later successful command overwrites them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data bus |
| mode_density | output | 2 | Partial-refresh density code |
| mode_page8 | output | 1 | Page-length flag, 1 = 8-word page |
| mode_valid | output | 1 | Register has been loaded at least once |
| seq_done | output | 1 | Command completed pulse |
| seq_fail | output | 1 | Command aborted pulse |

## Verification
The bench builds the block with a 4-bit address and 8-bit data. This makes the top address 0xF and shrinks each write word to 256 values. With that size, every value of the first command word and every value of the final command word can be swept. The expected density, page flag and pulse for each value are worked out arithmetically. The narrow address space also makes it cheap to mix in non-top accesses. Directed sequences cover reads with and without an output-enable toggle, out-of-order accesses, the third-read lockout and its release.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD1  = 2'd1,
    ST_RD2  = 2'd2,
    ST_WR1  = 2'd3
  } seq_state_e;

  localparam int unsigned DENS_W = 2;
  localparam int unsigned PAGE_BIT = 2;
endpackage

// File: rtl/bus_cycle_tracker.sv
module bus_cycle_tracker #(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ev_valid,
  output logic              ev_write,
  output logic              ev_oe_fell,
  output logic [ADDR_W-1:0] ev_addr,
  output logic [DATA_W-1:0] ev_data
);
  logic              cs_q, oe_q;
  logic              we_seen, oe_fell;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic              oe_edge;

  assign oe_edge = oe_q & ~oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      oe_q     <= 1'b1;
      we_seen  <= 1'b0;
      oe_fell  <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      cs_q <= cs_n;
      oe_q <= oe_n;
      if (!cs_n) begin
        if (cs_q) begin
          we_seen <= ~we_n;
          oe_fell <= oe_edge;
        end else begin
          we_seen <= we_seen | ~we_n;
          oe_fell <= oe_fell | oe_edge;
        end
        cap_addr <= addr;
        if (!we_n) cap_data <= wdata;
      end
    end
  end

  assign ev_valid   = ~cs_q & cs_n;
  assign ev_write   = we_seen;
  assign ev_oe_fell = oe_fell;
  assign ev_addr    = cap_addr;
  assign ev_data    = cap_data;
endmodule

// File: rtl/cmd_matcher.sv
module cmd_matcher #(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned DATA_W = 16
) (
  input  logic [ADDR_W-1:0]          ev_addr,
  input  logic [DATA_W-1:0]          ev_data,
  output logic                       is_top,
  output logic                       first_ok,
  output logic                       final_ok,
  output logic [mrs_pkg::DENS_W-1:0] dens_code,
  output logic                       page_flag
);
  localparam int unsigned HI_LSB = mrs_pkg::PAGE_BIT + 1;

  assign is_top    = &ev_addr;
  assign first_ok  = (ev_data == '0);
  assign dens_code = ev_data[mrs_pkg::DENS_W-1:0];
  assign page_flag = ev_data[mrs_pkg::PAGE_BIT];

  generate
    if (DATA_W > HI_LSB) begin : g_hi
      assign final_ok = page_flag && (ev_data[DATA_W-1:HI_LSB] == '0);
    end else begin : g_nohi
      assign final_ok = page_flag;
    end
  endgenerate
endmodule

// File: rtl/unlock_fsm.sv
module unlock_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_valid,
  input  logic ev_write,
  input  logic ev_oe_fell,
  input  logic is_top,
  input  logic first_ok,
  input  logic final_ok,
  output logic load,
  output logic done_q,
  output logic fail_q
);
  import mrs_pkg::*;

  seq_state_e state, nxt;
  logic       armed, nxt_armed;
  logic       fail;

  always_comb begin
    nxt       = state;
    nxt_armed = armed;
    load      = 1'b0;
    fail      = 1'b0;
    if (ev_valid) begin
      if (!is_top) begin
        nxt       = ST_IDLE;
        nxt_armed = 1'b1;
        fail      = (state != ST_IDLE);
      end else if (!ev_write) begin
        if (state == ST_IDLE && armed && ev_oe_fell) begin
          nxt = ST_RD1;
        end else if (state == ST_RD1 && ev_oe_fell) begin
          nxt = ST_RD2;
        end else begin
          nxt       = ST_IDLE;
          nxt_armed = 1'b0;
          fail      = (state != ST_IDLE);
        end
      end else begin
        if (state == ST_RD2 && first_ok) begin
          nxt = ST_WR1;
        end else if (state == ST_WR1 && final_ok) begin
          nxt  = ST_IDLE;
          load = 1'b1;
        end else begin
          nxt  = ST_IDLE;
          fail = (state != ST_IDLE);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      armed  <= 1'b1;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      state  <= nxt;
      armed  <= nxt_armed;
      done_q <= load;
      fail_q <= fail;
    end
  end
endmodule

// File: rtl/mode_reg_store.sv
module mode_reg_store (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [mrs_pkg::DENS_W-1:0] dens_in,
  input  logic                       page_in,
  output logic [mrs_pkg::DENS_W-1:0] dens_q,
  output logic                       page_q,
  output logic                       valid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dens_q  <= '0;
      page_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (load) begin
      dens_q  <= dens_in;
      page_q  <= page_in;
      valid_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sram_mode_unlock.sv
module sram_mode_unlock #(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [1:0]        mode_density,
  output logic              mode_page8,
  output logic              mode_valid,
  output logic              seq_done,
  output logic              seq_fail
);
  logic              ev_valid, ev_write, ev_oe_fell;
  logic [ADDR_W-1:0] ev_addr;
  logic [DATA_W-1:0] ev_data;
  logic              is_top, first_ok, final_ok, page_flag, load;
  logic [1:0]        dens_code;

  bus_cycle_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .ev_valid(ev_valid), .ev_write(ev_write),
    .ev_oe_fell(ev_oe_fell), .ev_addr(ev_addr), .ev_data(ev_data)
  );

  cmd_matcher #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .ev_addr(ev_addr), .ev_data(ev_data), .is_top(is_top),
    .first_ok(first_ok), .final_ok(final_ok), .dens_code(dens_code),
    .page_flag(page_flag)
  );

  unlock_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_write(ev_write),
    .ev_oe_fell(ev_oe_fell), .is_top(is_top), .first_ok(first_ok),
    .final_ok(final_ok), .load(load), .done_q(seq_done), .fail_q(seq_fail)
  );

  mode_reg_store u_reg (
    .clk(clk), .rst_n(rst_n), .load(load), .dens_in(dens_code),
    .page_in(page_flag), .dens_q(mode_density), .page_q(mode_page8),
    .valid_q(mode_valid)
  );
endmodule

// File: rtl/sram_mode_unlock_chk.sv
module sram_mode_unlock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic [1:0] mode_density,
  input logic       mode_page8,
  input logic       mode_valid,
  input logic       seq_done,
  input logic       seq_fail
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_done && seq_fail)); // R9
  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done); // R9
  AST_FAIL_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fail |=> !seq_fail); // R9
  AST_DONE_AFTER_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> ($past(cs_n) && !$past(cs_n, 2))); // R2
  AST_DONE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> mode_valid); // R3
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_valid) |-> mode_valid); // R10
  AST_HOLD_WITHOUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_done |-> ($stable(mode_density) && $stable(mode_page8))); // R10
endmodule

bind sram_mode_unlock sram_mode_unlock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mode_density(mode_density),
  .mode_page8(mode_page8), .mode_valid(mode_valid), .seq_done(seq_done),
  .seq_fail(seq_fail)
);

// File: tb/sram_mode_unlock_tb.sv
module sram_mode_unlock_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam logic [AW-1:0] TOP = '1;

  logic clk = 0, rst_n = 0, cs_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0] mode_density;
  logic mode_page8, mode_valid, seq_done, seq_fail;

  int n_chk = 0, n_err = 0;
  logic got_done, got_fail;
  logic [1:0] exp_dens = 0;
  logic exp_page = 0, exp_valid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_mode_unlock #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .mode_density(mode_density),
    .mode_page8(mode_page8), .mode_valid(mode_valid),
    .seq_done(seq_done), .seq_fail(seq_fail)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one bus cycle; afterwards got_done/got_fail hold the pulses seen
  task automatic bus(input bit wr, input bit oe_tog, input logic [AW-1:0] a,
                     input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    oe_n = (!wr && !oe_tog) ? 1'b0 : 1'b1;
    @(negedge clk);
    cs_n = 0; we_n = !wr; oe_n = wr ? 1'b1 : 1'b0;
    @(negedge clk);
    @(negedge clk);
    cs_n = 1; we_n = 1; oe_n = 1;
    @(negedge clk);
    got_done = seq_done; got_fail = seq_fail;
    @(negedge clk);
    if (seq_done || seq_fail) begin
      n_chk++; n_err++;
      $display("FAIL R9: pulse longer than one clock actual=1 expected=0");
    end
  endtask

  task automatic check_reg(input string req);
    check({req, " density"}, mode_density, exp_dens);
    check({req, " page"}, mode_page8, exp_page);
    check({req, " valid"}, mode_valid, exp_valid);
  endtask

  task automatic unlock(input logic [DW-1:0] d1, input logic [DW-1:0] d2);
    bus(0, 1, TOP, 0);
    bus(0, 1, TOP, 0);
    bus(1, 0, TOP, d1);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", mode_valid, 0);
    check("R1 density", mode_density, 0);
    check("R1 page", mode_page8, 0);
    check("R1 done", seq_done, 0);
    check("R1 fail", seq_fail, 0);
    rst_n = 1;

    // R3 basic command, R2 classification
    unlock(8'h00, 8'h06);
    check("R3 first write accepted no fail", got_fail, 0);
    bus(1, 0, TOP, 8'h06);
    exp_dens = 2'b10; exp_page = 1; exp_valid = 1;
    check("R3 done", got_done, 1);
    check_reg("R3");

    // R3/R6 sweep of the final word
    for (int v = 0; v < 256; v++) begin
      bit good;
      good = (v[7:3] == 0) && v[2];
      unlock(8'h00, v[7:0]);
      bus(1, 0, TOP, v[7:0]);
      if (good) begin exp_dens = v[1:0]; exp_page = 1; end
      check("R6 final word done", got_done, good);
      check("R6 final word fail", got_fail, !good);
      check("R10 register after final word", {mode_page8, mode_density},
            {exp_page, exp_dens});
    end

    // R5 sweep of the first word
    for (int v = 0; v < 256; v++) begin
      logic f3;
      logic [1:0] dn;
      dn = v[1:0] ^ 2'b11;
      unlock(v[7:0], 8'h04);
      f3 = got_fail;
      bus(1, 0, TOP, {6'b000001, dn});
      if (v == 0) exp_dens = dn;
      check("R5 first word fail", f3, v != 0);
      check("R5 done", got_done, v == 0);
      check("R5 density", mode_density, exp_dens);
    end

    // R7 non-top read aborts mid sequence; idle non-top read is silent
    bus(0, 1, 4'h3, 0);
    check("R7 idle non-top no fail", got_fail, 0);
    bus(0, 1, TOP, 0);
    bus(0, 1, 4'h7, 0);
    check("R7 abort fail", got_fail, 1);
    check_reg("R7");
    unlock(0, 8'h05);
    bus(1, 0, TOP, 8'h05);
    exp_dens = 2'b01;
    check("R7 recover done", got_done, 1);
    check_reg("R7 recover");

    // R8 wrong order: write where read expected
    bus(0, 1, TOP, 0);
    bus(1, 0, TOP, 0);
    check("R8 wrong order fail", got_fail, 1);
    // R8 read where write expected (third top read) then lockout
    bus(0, 1, 4'h0, 0);
    bus(0, 1, TOP, 0);
    bus(0, 1, TOP, 0);
    bus(0, 1, TOP, 0);
    check("R8 third read fail", got_fail, 1);
    bus(0, 1, TOP, 0);
    check("R8 locked read silent", got_fail, 0);
    bus(0, 1, TOP, 0);
    bus(1, 0, TOP, 0);
    bus(1, 0, TOP, 8'h07);
    check("R8 locked no done", got_done, 0);
    check_reg("R8 locked");
    bus(0, 1, 4'h2, 0);
    unlock(0, 8'h07);
    bus(1, 0, TOP, 8'h07);
    exp_dens = 2'b11;
    check("R8 release done", got_done, 1);
    check_reg("R8 release");

    // R4 read without OE toggle does not count
    bus(0, 0, TOP, 0);
    check("R4 idle untoggled no fail", got_fail, 0);
    bus(0, 1, TOP, 0);
    bus(0, 1, TOP, 0);
    bus(1, 0, TOP, 0);
    bus(1, 0, TOP, 8'h04);
    check("R4 blocked no done", got_done, 0);
    bus(0, 1, 4'h1, 0);
    bus(0, 1, TOP, 0);
    bus(0, 0, TOP, 0);
    check("R4 second read untoggled fail", got_fail, 1);
    check_reg("R4");
    bus(0, 1, 4'h1, 0);
    unlock(0, 8'h04);
    bus(1, 0, TOP, 8'h04);
    exp_dens = 2'b00;
    check("R4 toggled done", got_done, 1);
    check_reg("R10 overwrite");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule